// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the system clock. A 4-bit prescale value sets the half period in steps of two system clocks, and an optional slow-range flag stretches every half period by a further factor of sixteen. A per-frame idle polarity input selects the level the serial clock rests at between frames.

Besides the clock level itself, the block emits two one-cycle strobes: one in the cycle the clock leaves its idle level (leading edge) and one in the cycle it returns (trailing edge). A shift engine uses these to sample and launch data without having to detect edges on the clock itself. Deasserting the enable input at the end of a frame resets the divider, so every frame starts from the same phase. The prescale, slow-range and polarity inputs are captured only while the block is disabled. Inside a frame the settings stay fixed.

Top module: `sck_prescaler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sckOut is 0 and leadStrobe and trailStrobe are 0.
- R2: With slowRange clear, each half period of sckOut lasts 2×(prescale+1) system clocks. The first transition happens at the H-th rising edge that samples enable high, where H is the half period. After that, a transition follows every H edges.
- R3: With slowRange set, each half period lasts 32×(prescale+1) system clocks. The output period is therefore the system clock divided by 64×(prescale+1).
- R4: Both ends of the prescale range (0 and 15) behave as R2 and R3 state. This gives a shortest half period of 2 and a longest of 512 system clocks.
- R5: The idle level of sckOut equals idleHigh (1 = rests high, 0 = rests low). leadStrobe marks the transition away from the idle level and trailStrobe the transition back to it.
- R6: A rising edge that samples enable low drives sckOut to the idle level at that edge with no strobe and restarts the divider. The next frame repeats the timing of R2.
- R7: Each strobe is one system clock wide and coincides with the cycle in which sckOut shows its new level. The two strobes are never high together, and sckOut never changes during a frame without a strobe.
- R8: Changes to prescale and slowRange while enable is high have no effect on the running frame. These inputs are captured only on edges that sample enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | High for the duration of a frame |
| prescale | input | 4 | Half-period step count minus one |
| slowRange | input | 1 | Multiplies the half period by 16 |
| idleHigh | input | 1 | Serial clock idle level |
| sckOut | output | 1 | Serial clock |
| leadStrobe | output | 1 | One-cycle mark of the leading edge |
| trailStrobe | output | 1 | One-cycle mark of the trailing edge |

## Verification
A half-period counter that loads a wrong terminal value, or that fails to clear when the block is disabled, shows as a strobe landing on the wrong system-clock cycle. This becomes visible at the first edge of a frame, H cycles after enable, and is caught there by comparing the exact cycle number. A phase bit that is out of step with the idle level shows as a leading strobe whose clock level equals the idle level, or as a clock that stays away from idle one cycle after disable. Each of these fails at the first edge or first idle cycle where it occurs.

// File: rtl/sck_prescaler_pkg.sv
package sck_prescaler_pkg;

  // Command from the divider control to the clock datapath.
  typedef struct packed {
    logic hold;       // block disabled: force idle, no strobes
    logic idleLevel;  // level the clock rests at
    logic goActive;   // leave idle level at this edge
    logic goIdle;     // return to idle level at this edge
  } sckCmd_t;

endpackage

// File: rtl/sck_prescaler_ctrl.sv
module sck_prescaler_ctrl
  import sck_prescaler_pkg::*;
#(
  parameter int PM_W        = 4,
  parameter int QUANTUM     = 2,
  parameter int SLOW_FACTOR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [PM_W-1:0] prescale,
  input  logic            slowRange,
  input  logic            idleHigh,
  output sckCmd_t         cmd
);

  localparam int MAX_HALF = QUANTUM * (1 << PM_W) * SLOW_FACTOR;
  localparam int CNT_W    = $clog2(MAX_HALF);

  logic [PM_W-1:0]  pmQ;
  logic             slowQ;
  logic             polQ;
  logic [CNT_W-1:0] halfCnt;
  logic             active;
  logic [31:0]      halfLen;
  logic             terminal;

  // Half period in system clocks; the slow range is a pure scale factor.
  generate
    if (SLOW_FACTOR > 1) begin : g_slow
      always_comb
        halfLen = (32'(pmQ) + 32'd1) * 32'(QUANTUM) * (slowQ ? 32'(SLOW_FACTOR) : 32'd1);
    end else begin : g_noslow
      always_comb
        halfLen = (32'(pmQ) + 32'd1) * 32'(QUANTUM);
    end
  endgenerate

  assign terminal = (32'(halfCnt) == halfLen - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halfCnt <= '0;
      active  <= 1'b0;
      pmQ     <= '0;
      slowQ   <= 1'b0;
      polQ    <= 1'b0;
    end else if (!enable) begin
      halfCnt <= '0;
      active  <= 1'b0;
      pmQ     <= prescale;
      slowQ   <= slowRange;
      polQ    <= idleHigh;
    end else if (terminal) begin
      halfCnt <= '0;
      active  <= ~active;
    end else begin
      halfCnt <= halfCnt + CNT_W'(1);
    end
  end

  always_comb begin
    cmd.hold      = ~enable;
    cmd.idleLevel = enable ? polQ : idleHigh;
    cmd.goActive  = enable & terminal & ~active;
    cmd.goIdle    = enable & terminal & active;
  end

endmodule

// File: rtl/sck_prescaler_dp.sv
module sck_prescaler_dp
  import sck_prescaler_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sckCmd_t cmd,
  output logic    sckOut,
  output logic    leadStrobe,
  output logic    trailStrobe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckOut      <= 1'b0;
      leadStrobe  <= 1'b0;
      trailStrobe <= 1'b0;
    end else begin
      leadStrobe  <= cmd.goActive;
      trailStrobe <= cmd.goIdle;
      if (cmd.hold)          sckOut <= cmd.idleLevel;
      else if (cmd.goActive) sckOut <= ~cmd.idleLevel;
      else if (cmd.goIdle)   sckOut <= cmd.idleLevel;
    end
  end

endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
  import sck_prescaler_pkg::*;
#(
  parameter int PM_W        = 4,
  parameter int QUANTUM     = 2,
  parameter int SLOW_FACTOR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [PM_W-1:0] prescale,
  input  logic            slowRange,
  input  logic            idleHigh,
  output logic            sckOut,
  output logic            leadStrobe,
  output logic            trailStrobe
);

  sckCmd_t cmd;

  sck_prescaler_ctrl #(
    .PM_W(PM_W), .QUANTUM(QUANTUM), .SLOW_FACTOR(SLOW_FACTOR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
    .slowRange(slowRange), .idleHigh(idleHigh), .cmd(cmd)
  );

  sck_prescaler_dp u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .sckOut(sckOut), .leadStrobe(leadStrobe), .trailStrobe(trailStrobe)
  );

endmodule

// File: rtl/sck_prescaler_checker.sv
module sck_prescaler_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic idleHigh,
  input logic sckOut,
  input logic leadStrobe,
  input logic trailStrobe
);

  // R7: strobes are mutually exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(leadStrobe && trailStrobe));

  // R7: a strobe coincides with a change of the clock level
  a_r7_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (leadStrobe || trailStrobe) |-> (sckOut != $past(sckOut)));

  // R7: within a frame the clock only changes with a strobe
  a_r7_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && (sckOut != $past(sckOut))) |-> (leadStrobe || trailStrobe));

  // R7 and R2: a strobe is one cycle wide, half period is at least two
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (leadStrobe || trailStrobe) |=> !(leadStrobe || trailStrobe));

  // R6: a disabled edge forces the idle level and no strobe
  a_r6_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((sckOut == $past(idleHigh)) && !leadStrobe && !trailStrobe));

endmodule

bind sck_prescaler sck_prescaler_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .idleHigh(idleHigh),
  .sckOut(sckOut), .leadStrobe(leadStrobe), .trailStrobe(trailStrobe)
);

// File: tb/tb_sck_prescaler.sv
`timescale 1ns/1ps
module tb_sck_prescaler;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] prescale = 4'd0;
  logic       slowRange = 1'b0;
  logic       idleHigh = 1'b0;
  logic       sckOut, leadStrobe, trailStrobe;

  sck_prescaler dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
    .slowRange(slowRange), .idleHigh(idleHigh),
    .sckOut(sckOut), .leadStrobe(leadStrobe), .trailStrobe(trailStrobe)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  typedef struct { int cycle; bit isLead; bit level; } expEdge_t;
  expEdge_t expQ[$];

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expected edge whenever a strobe appears.
  always @(negedge clk) begin
    expEdge_t e;
    if (rst_n && !done) begin
      if (leadStrobe && trailStrobe) check(1'b0, "R7", "both strobes high", 1, 0);
      if (leadStrobe || trailStrobe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 R7", "unexpected strobe at cycle", cyc, -1);
        end else begin
          e = expQ.pop_front();
          check(e.cycle == cyc, "R2", "edge cycle", cyc, e.cycle);
          check(leadStrobe == e.isLead, "R5", "leading strobe", int'(leadStrobe), int'(e.isLead));
          check(sckOut == e.level, "R5", "sck after edge", int'(sckOut), int'(e.level));
        end
      end
    end
  end

  // Driver: one frame of 'halves' half periods, then disable.
  task automatic runFrame(input int pmV, input bit d16, input bit idl,
                          input int halves, input bit poke);
    int h;
    int c;
    @(negedge clk);
    enable = 1'b0; prescale = pmV[3:0]; slowRange = d16; idleHigh = idl;
    @(negedge clk);
    check(sckOut == idl, "R5", "idle level before frame", int'(sckOut), int'(idl));
    h = 2 * (pmV + 1) * (d16 ? 16 : 1);
    enable = 1'b1;
    c = cyc;
    for (int k = 1; k <= halves; k++)
      expQ.push_back('{c + k * h, bit'((k % 2) == 1), ((k % 2) == 1) ? !idl : idl});
    if (poke) begin
      @(negedge clk);
      prescale  = ~prescale;   // R8: must not disturb the running frame
      slowRange = ~slowRange;
    end
    while (cyc < c + halves * h + 1) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(sckOut == idl, "R6", "sck one cycle after disable", int'(sckOut), int'(idl));
    check(!leadStrobe && !trailStrobe, "R6", "strobe after disable",
          int'(leadStrobe || trailStrobe), 0);
    check(expQ.size() == 0, "R2", "edges still pending", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sckOut == 1'b0 && !leadStrobe && !trailStrobe, "R1", "outputs in reset",
          int'({sckOut, leadStrobe, trailStrobe}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sckOut == 1'b0 && !leadStrobe && !trailStrobe, "R1", "outputs after reset",
          int'({sckOut, leadStrobe, trailStrobe}), 0);

    runFrame(0,  1'b0, 1'b0, 6, 1'b0);  // R2 R4 fastest
    runFrame(5,  1'b0, 1'b1, 5, 1'b0);  // R5 idle high, R6 disable while active
    runFrame(15, 1'b0, 1'b0, 4, 1'b0);  // R4 top of range
    runFrame(0,  1'b1, 1'b1, 3, 1'b0);  // R3 slow range
    runFrame(3,  1'b0, 1'b0, 4, 1'b1);  // R8 settings changed mid-frame
    runFrame(15, 1'b1, 1'b0, 2, 1'b0);  // R3 R4 slowest
    runFrame(2,  1'b0, 1'b0, 3, 1'b0);  // R6 fresh phase after prior frame

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule